// File: doc/BRIEF.md
# DMA Bus Address Map Registers

This block holds the page map that a bus adapter uses to turn 18-bit device bus addresses into 22-bit physical addresses for DMA. The 18-bit bus space is cut into 32 pages of 8 KB each. Every page has one 22-bit map entry that gives its physical base address. The processor sees each entry as two 16-bit registers at consecutive word addresses. The even register holds the low half of the entry and the odd register holds the top six bits. Both registers accept full-word writes and single-byte writes.

A separate translation port takes a bus address and returns the physical address one clock later. It adds the page offset to the entry of the selected page. The topmost bus page never uses its entry: it always lands in the fixed I/O page at physical 0x3FE000. When the map-enable input is low, bus addresses pass through without translation. The translated-address output holds its last result until the next request, so it also serves as the record of the most recent translation.

Top module: `dma_page_map`

## Requirements
- R1: After reset, every map entry reads as zero through both of its registers, and `xl_phys` is zero.
- R2: Register access selects entry `reg_addr[6:2]`. When `reg_addr[1]`=0, `reg_rdata` returns entry bits 15:0 one cycle after the address is presented, and bit 0 is always zero.
- R3: When `reg_addr[1]`=1, `reg_rdata[5:0]` returns entry bits 21:16 and `reg_rdata[15:6]` is zero.
- R4: A byte write (`reg_we`=1, `reg_byte`=1) places `reg_wdata[7:0]` into entry bits [8*L+7:8*L], where L=`reg_addr[1:0]`. Lane L=3 lies wholly above bit 21, so a write to it leaves the entry unchanged.
- R5: A word write (`reg_we`=1, `reg_byte`=0) places `reg_wdata` into entry bits 15:0 when `reg_addr[1]`=0, and into bits 31:16 when `reg_addr[1]`=1. Bit `reg_addr[0]` is ignored.
- R6: After every write, the stored entry keeps only bits 21:0 and has bit 0 cleared.
- R7: When `xl_req`=1 and `map_en`=1 for a page number `xl_bus_addr[17:13]` below 31, `xl_phys` becomes (entry + `xl_bus_addr[12:0]`) mod 2^22 at the next clock edge.
- R8: When `xl_req`=1 and `map_en`=1 for page 31, `xl_phys` becomes 0x3FE000 + `xl_bus_addr[12:0]`, whatever entry 31 holds.
- R9: When `xl_req`=1 and `map_en`=0, `xl_phys` becomes `xl_bus_addr` zero-extended to 22 bits.
- R10: While `xl_req`=0, `xl_phys` keeps its previous value.
- R11: A translation requested in the same cycle as a write to its page's entry uses the entry value from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| map_en | input | 1 | Enables translation through the map |
| reg_we | input | 1 | Register write strobe |
| reg_byte | input | 1 | 1 = byte write, 0 = word write |
| reg_addr | input | 7 | Register byte address (entry index in bits 6:2) |
| reg_wdata | input | 16 | Write data (the byte is taken from bits 7:0) |
| reg_rdata | output | 16 | Registered read data for `reg_addr` |
| xl_req | input | 1 | Translation request |
| xl_bus_addr | input | 18 | Bus address to translate |
| xl_phys | output | 22 | Registered physical address of the most recent translation |

## Verification
A processor write to a map entry and a translation that uses the same entry can arrive on the same clock edge. The bench provokes this by writing a new value to the page's even register in the very cycle that it requests a translation for that page. The result is judged correct only if it equals the sum built from the old entry. A second translation, issued after the write, must then show the new entry, which proves that the write did take effect.

// File: rtl/dma_page_map_pkg.sv
package dma_page_map_pkg;
  localparam int BUS_AW_D  = 18;
  localparam int PHYS_AW_D = 22;
  localparam int OFF_W_D   = 13;
  localparam int REG_W_D   = 16;
  localparam logic [PHYS_AW_D-1:0] IO_BASE_D = 22'h3FE000;
endpackage

// File: rtl/dma_map_store.sv
module dma_map_store #(
  parameter int PHYS_AW = 22,
  parameter int PAGE_W  = 5,
  parameter int REG_W   = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic               wr_byte,
  input  logic [PAGE_W-1:0]  wr_idx,
  input  logic [1:0]         wr_lane,
  input  logic [REG_W-1:0]   wr_data,
  input  logic [PAGE_W-1:0]  rd_idx,
  output logic [PHYS_AW-1:0] rd_entry,
  input  logic [PAGE_W-1:0]  xl_idx,
  output logic [PHYS_AW-1:0] xl_entry
);
  localparam int ENTRIES = 1 << PAGE_W;
  localparam int WIDE    = 2 * REG_W;

  logic [PHYS_AW-1:0] entry_q [ENTRIES];
  logic [WIDE-1:0]    cur_w, new_w;
  logic [PHYS_AW-1:0] merged;

  always_comb begin
    cur_w = {{(WIDE-PHYS_AW){1'b0}}, entry_q[wr_idx]};
    new_w = cur_w;
    if (wr_byte) new_w[{wr_lane, 3'b000} +: 8] = wr_data[7:0];
    else         new_w[wr_lane[1]*REG_W +: REG_W] = wr_data;
    merged = new_w[PHYS_AW-1:0] & ~{{(PHYS_AW-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) entry_q[i] <= '0;
    end else if (wr_en) begin
      entry_q[wr_idx] <= merged;
    end
  end

  assign rd_entry = entry_q[rd_idx];
  assign xl_entry = entry_q[xl_idx];

  // byte lane 3 is above the entry width: entry must be untouched (R4)
  assert_lane3_noop_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_byte && wr_lane == 2'd3) |=> entry_q[$past(wr_idx)] == $past(entry_q[wr_idx]));
endmodule

// File: rtl/dma_xlate_unit.sv
module dma_xlate_unit #(
  parameter int BUS_AW  = 18,
  parameter int PHYS_AW = 22,
  parameter int OFF_W   = 13,
  parameter logic [PHYS_AW-1:0] IO_BASE = 22'h3FE000
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      req,
  input  logic                      map_en,
  input  logic [BUS_AW-1:0]         bus_addr,
  output logic [BUS_AW-OFF_W-1:0]   page,
  input  logic [PHYS_AW-1:0]        entry,
  output logic [PHYS_AW-1:0]        phys
);
  localparam int PAGE_W = BUS_AW - OFF_W;

  logic [PHYS_AW-1:0] off_ext, nxt;
  logic               top_page;

  assign page     = bus_addr[BUS_AW-1:OFF_W];
  assign top_page = &page;
  assign off_ext  = {{(PHYS_AW-OFF_W){1'b0}}, bus_addr[OFF_W-1:0]};

  always_comb begin
    if (!map_en)       nxt = {{(PHYS_AW-BUS_AW){1'b0}}, bus_addr};
    else if (top_page) nxt = IO_BASE + off_ext;
    else               nxt = entry + off_ext;
  end

  always_ff @(posedge clk) begin
    if (rst)      phys <= '0;
    else if (req) phys <= nxt;
  end

  // top page always lands in the I/O page (R8)
  assert_io_page_R8: assert property (@(posedge clk) disable iff (rst)
    (req && map_en && page == {PAGE_W{1'b1}}) |=> phys[PHYS_AW-1:OFF_W] == IO_BASE[PHYS_AW-1:OFF_W]);
  // result holds between requests (R10)
  assert_phys_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !req |=> $stable(phys));
endmodule

// File: rtl/dma_page_map.sv
module dma_page_map
  import dma_page_map_pkg::*;
#(
  parameter int BUS_AW  = BUS_AW_D,
  parameter int PHYS_AW = PHYS_AW_D,
  parameter int OFF_W   = OFF_W_D,
  parameter int REG_W   = REG_W_D,
  parameter logic [PHYS_AW-1:0] IO_BASE = IO_BASE_D,
  localparam int PAGE_W = BUS_AW - OFF_W,
  localparam int REG_AW = PAGE_W + 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               map_en,
  input  logic               reg_we,
  input  logic               reg_byte,
  input  logic [REG_AW-1:0]  reg_addr,
  input  logic [REG_W-1:0]   reg_wdata,
  output logic [REG_W-1:0]   reg_rdata,
  input  logic               xl_req,
  input  logic [BUS_AW-1:0]  xl_bus_addr,
  output logic [PHYS_AW-1:0] xl_phys
);
  logic [PHYS_AW-1:0] rd_entry, xl_entry;
  logic [PAGE_W-1:0]  xl_page;
  logic [REG_W-1:0]   rd_sel;

  dma_map_store #(.PHYS_AW(PHYS_AW), .PAGE_W(PAGE_W), .REG_W(REG_W)) store_i (
    .clk(clk), .rst(rst),
    .wr_en(reg_we), .wr_byte(reg_byte),
    .wr_idx(reg_addr[REG_AW-1:2]), .wr_lane(reg_addr[1:0]), .wr_data(reg_wdata),
    .rd_idx(reg_addr[REG_AW-1:2]), .rd_entry(rd_entry),
    .xl_idx(xl_page), .xl_entry(xl_entry)
  );

  dma_xlate_unit #(.BUS_AW(BUS_AW), .PHYS_AW(PHYS_AW), .OFF_W(OFF_W), .IO_BASE(IO_BASE)) xl_i (
    .clk(clk), .rst(rst), .req(xl_req), .map_en(map_en),
    .bus_addr(xl_bus_addr), .page(xl_page), .entry(xl_entry), .phys(xl_phys)
  );

  always_comb begin
    if (reg_addr[1]) rd_sel = {{(2*REG_W-PHYS_AW){1'b0}}, rd_entry[PHYS_AW-1:REG_W]};
    else             rd_sel = rd_entry[REG_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_sel;
  end

  // even register never shows bit 0 set (R2)
  assert_even_lsb_R2: assert property (@(posedge clk) disable iff (rst)
    !reg_addr[1] |=> !reg_rdata[0]);
  // odd register upper bits are zero (R3)
  assert_odd_upper_R3: assert property (@(posedge clk) disable iff (rst)
    reg_addr[1] |=> reg_rdata[REG_W-1:PHYS_AW-REG_W] == '0);
  // map disabled: straight pass-through (R9)
  assert_bypass_R9: assert property (@(posedge clk) disable iff (rst)
    (xl_req && !map_en) |=> xl_phys == {{(PHYS_AW-BUS_AW){1'b0}}, $past(xl_bus_addr)});
endmodule

// File: tb/dma_page_map_tb.sv
module dma_page_map_tb_top;
  logic        clk = 0;
  logic        rst = 1;
  logic        map_en = 1;
  logic        reg_we = 0, reg_byte = 0;
  logic [6:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        xl_req = 0;
  logic [17:0] xl_bus_addr = '0;
  logic [21:0] xl_phys;

  int errors = 0, checks = 0;
  logic [21:0] model [32];

  always #2 clk = ~clk;

  dma_page_map dut_i (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // model of a register write, from R4/R5/R6
  task automatic model_wr(input logic [6:0] a, input logic [15:0] d, input logic byt);
    logic [31:0] w = {10'b0, model[a[6:2]]};
    if (byt) w[a[1:0]*8 +: 8] = d[7:0];
    else     w[a[1]*16 +: 16] = d;
    model[a[6:2]] = w[21:0] & 22'h3FFFFE;
  endtask

  task automatic reg_write(input logic [6:0] a, input logic [15:0] d, input logic byt);
    @(negedge clk);
    reg_we = 1; reg_byte = byt; reg_addr = a; reg_wdata = d;
    model_wr(a, d, byt);
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic reg_read_check(input string req, input logic [6:0] a);
    logic [15:0] exp;
    @(negedge clk);
    reg_addr = a;
    exp = a[1] ? {10'b0, model[a[6:2]][21:16]} : model[a[6:2]][15:0];
    @(negedge clk);
    check(req, {16'b0, reg_rdata}, {16'b0, exp});
  endtask

  task automatic xlate_check(input string req, input logic [17:0] ba, input logic [21:0] exp);
    @(negedge clk);
    xl_req = 1; xl_bus_addr = ba;
    @(negedge clk);
    xl_req = 0;
    check(req, {10'b0, xl_phys}, {10'b0, exp});
  endtask

  task automatic t_reset;
    reg_read_check("R1 even", 7'h0C);
    reg_read_check("R1 odd", 7'h7E);
    check("R1 phys", {10'b0, xl_phys}, 32'h0);
  endtask

  task automatic t_word;
    reg_write(7'h0C, 16'h1235, 0);
    reg_write(7'h0E, 16'hFFFF, 0);
    reg_read_check("R2/R6 even word", 7'h0C);
    check("R6 lsb cleared", {10'b0, model[3]}, 32'h003F1234);
    reg_read_check("R3 odd word", 7'h0E);
    reg_write(7'h21, 16'hBEEF, 0);          // addr bit0 ignored -> entry 8 low half
    reg_read_check("R5 addr0 ignored", 7'h20);
    check("R5 model", {10'b0, model[8]}, 32'h0000BEEE);
  endtask

  task automatic t_byte;
    reg_write(7'h14, 16'h55AB, 1);
    reg_write(7'h15, 16'h99CD, 1);
    reg_write(7'h16, 16'h00FF, 1);
    reg_read_check("R4 lanes 0/1", 7'h14);
    reg_read_check("R4 lane 2", 7'h16);
    reg_write(7'h17, 16'h0077, 1);          // lane 3: no effect
    reg_read_check("R4 lane3 even", 7'h14);
    reg_read_check("R4 lane3 odd", 7'h16);
    check("R4 value", {10'b0, model[5]}, 32'h003FCDAA);
  endtask

  task automatic t_xlate;
    map_en = 1;
    xlate_check("R7 page3", {5'd3, 13'h0ABC}, 22'h3F1234 + 22'h0ABC);
    reg_write(7'h10, 16'hFFFE, 0);
    reg_write(7'h12, 16'h003F, 0);          // entry 4 = 0x3FFFFE
    xlate_check("R7 wrap", {5'd4, 13'h1FFF}, 22'h001FFD);
    xlate_check("R7 page0 zero", {5'd0, 13'h0042}, 22'h000042);
    reg_write(7'h7C, 16'h4444, 0);          // entry 31 ignored
    xlate_check("R8 io page", {5'd31, 13'h0123}, 22'h3FE123);
    xlate_check("R8 io top", {5'd31, 13'h1FFF}, 22'h3FFFFF);
  endtask

  task automatic t_bypass;
    map_en = 0;
    xlate_check("R9 bypass", {5'd3, 13'h0ABC}, {4'b0, 5'd3, 13'h0ABC});
    xlate_check("R9 bypass top", 18'h3FFFF, 22'h03FFFF);
    map_en = 1;
  endtask

  task automatic t_hold;
    xlate_check("R10 set", {5'd5, 13'h0010}, 22'h3FCDAA + 22'h10);
    @(negedge clk); xl_bus_addr = {5'd0, 13'h0001};
    @(negedge clk); @(negedge clk);
    check("R10 hold", {10'b0, xl_phys}, {10'b0, 22'h3FCDBA});
  endtask

  task automatic t_collide;
    logic [21:0] old_e = model[3];
    @(negedge clk);
    reg_we = 1; reg_byte = 0; reg_addr = 7'h0C; reg_wdata = 16'h8000;
    xl_req = 1; xl_bus_addr = {5'd3, 13'h0004};
    model_wr(7'h0C, 16'h8000, 0);
    @(negedge clk);
    reg_we = 0; xl_req = 0;
    check("R11 old entry", {10'b0, xl_phys}, {10'b0, old_e + 22'h4});
    xlate_check("R11 new entry", {5'd3, 13'h0004}, model[3] + 22'h4);
  endtask

  initial begin : watchdog
    #400000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_word();
    t_byte();
    t_xlate();
    t_bypass();
    t_hold();
    t_collide();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule